// File: doc/BRIEF.md
# Network Controller Interrupt Status and Enable Registers

This block holds the event status word and the interrupt enable word of a network controller. Single-cycle strobes from the transmit, receive, timer and bus logic each set one sticky status bit. Software reads the status word and writes the same value back to acknowledge. Every 1 written clears the matching bit. Two derived summary bits show whether any bit of the normal group or of the abnormal group is pending.

The enable word uses the same bit positions as the status word. Its two summary positions act as group gates. A registered, level-sensitive interrupt line is high while some enabled status bit belongs to a group whose gate is open. The status word also carries two read-only 3-bit fields. These reflect the current receive and transmit process states, which the DMA engines supply on input ports.

Register access is a plain address/data port with separate write and read strobes. Read data is registered, and it holds between reads. The asynchronous reset input is released inside the block through a two-stage synchronizer.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status bits, the enable word, `irq` and `reg_rdata` are all zero.
- R2: A strobe on `ev_strobe[i]` sets status bit i for i in {0,1,2,3,5,6,7,8,9,10,11,13,14}. Strobes on positions 4 and 12 have no effect, and status bits 4 and 12 always read 0.
- R3: A write to the status address (0) clears each implemented status bit whose `reg_wdata` bit is 1, and leaves the bits written with 0 unchanged.
- R4: When a strobe and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 16 reads 1 exactly when at least one of status bits 0, 2, 6, 11, 14 is set.
- R6: Status bit 15 reads 1 exactly when at least one of status bits 1, 3, 5, 7, 8, 9, 10, 13 is set.
- R7: Writes to status bits 15 to 31 have no effect, so summary and state fields cannot be written.
- R8: The enable word at address 1 is read/write on bits {0,1,2,3,5..11,13..16} and reads 0 on every other bit.
- R9: `irq` goes high on the cycle after a status bit becomes set, when that bit is enabled and its group gate is open. Enable bit 16 gates the group of R5 and enable bit 15 gates the group of R6. With the gate closed, `irq` stays low.
- R10: `irq` goes low on the cycle after the last enabled, gated status bit is cleared.
- R11: Status bits 19:17 show `rx_state` and bits 22:20 show `tx_state`. The transmit codes are 000 stopped, 001 fetching descriptor, 010 waiting, 011 reading buffer, 101 setup frame, 110 suspended, 111 closing descriptor.
- R12: `reg_rdata` loads on the clock edge that samples `reg_rd` and holds otherwise. Any address other than 0 and 1 reads as 0, and writes to such an address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_strobe | input | 15 | One-cycle event strobes, one per status position |
| rx_state | input | 3 | Current receive process state |
| tx_state | input | 3 | Current transmit process state |
| reg_addr | input | 4 | Register address (0 status, 1 enable) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a strobe and a write-back that land on the same bit in the same clock cycle. The bench drives the event vector and the write strobe on the same falling edge, then reads the word back to show the bit survived. A second hard area is the gating matrix. For every implemented position, the bench enables only that bit under all four combinations of the two group gates. It checks both the rise of `irq` one cycle after the event and its fall one cycle after the clear.

// File: rtl/irqsc_pkg.sv
package irqsc_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned EV_W     = 15;
  localparam int unsigned PS_W     = 3;
  localparam int unsigned ASUM_POS = 15;
  localparam int unsigned NSUM_POS = 16;
  localparam int unsigned RXS_LSB  = 17;
  localparam int unsigned TXS_LSB  = RXS_LSB + PS_W;
  localparam int unsigned PAD_W    = REG_W - TXS_LSB - PS_W;

  // group membership of the event positions
  localparam logic [EV_W-1:0] NRM_GRP = 15'h4845;
  localparam logic [EV_W-1:0] ABN_GRP = 15'h27AA;
  localparam logic [EV_W-1:0] EV_IMPL = NRM_GRP | ABN_GRP;

  // writable bits of the enable word: events plus both group gates
  localparam logic [REG_W-1:0] EN_WMASK =
    {{(REG_W-EV_W-2){1'b0}}, 2'b11, EV_IMPL};

  typedef enum logic [PS_W-1:0] {
    TXP_STOPPED  = 3'b000,
    TXP_FETCH    = 3'b001,
    TXP_WAIT     = 3'b010,
    TXP_READBUF  = 3'b011,
    TXP_SETUP    = 3'b101,
    TXP_SUSPEND  = 3'b110,
    TXP_CLOSE    = 3'b111
  } txp_state_e;
endpackage

// File: rtl/irqsc_status_bank.sv
module irqsc_status_bank
  import irqsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev,
  input  logic            clr_we,
  input  logic [EV_W-1:0] clr_data,
  output logic [EV_W-1:0] st_q
);
  logic upd;
  logic unused_ev;

  always_comb upd = clr_we | (|(ev & EV_IMPL));
  assign unused_ev = ^(ev & ~EV_IMPL);

  for (genvar i = 0; i < EV_W; i++) begin : g_bit
    if (EV_IMPL[i]) begin : g_flop
      logic q, d;
      always_comb d = ev[i] | (q & ~(clr_we & clr_data[i]));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (upd) q <= d;
      end
      assign st_q[i] = q;
    end else begin : g_tie
      assign st_q[i] = 1'b0;
    end
  end

  // R4: an event is never lost to a clearing write in the same cycle
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev & EV_IMPL)) |=> ((st_q & $past(ev & EV_IMPL)) == $past(ev & EV_IMPL)));

  // R3: a clearing write with no competing event clears the selected bits
  a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((ev & EV_IMPL) == '0)) |=> ((st_q & $past(clr_data)) == '0));

  // R2: a bit can only become set through its strobe
  a_r2_set_by_event_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(ev)) == '0));
endmodule

// File: rtl/irqsc_enable_reg.sv
module irqsc_enable_reg
  import irqsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_q
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (EN_WMASK[i]) begin : g_flop
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (we) q <= wdata[i];
      end
      assign en_q[i] = q;
    end else begin : g_tie
      assign en_q[i] = 1'b0;
    end
  end

  // R8: a write lands exactly on the writable bits
  a_r8_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (en_q == ($past(wdata) & EN_WMASK)));
endmodule

// File: rtl/irqsc_irq_gen.sv
module irqsc_irq_gen
  import irqsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EV_W-1:0]  st,
  input  logic [REG_W-1:0] en,
  output logic             nsum,
  output logic             asum,
  output logic             irq
);
  logic [EV_W-1:0] st_en;
  logic            n_hit, a_hit, irq_d, irq_q;
  logic            unused_en;

  assign unused_en = ^en[REG_W-1:NSUM_POS+1];

  always_comb begin
    nsum  = |(st & NRM_GRP);
    asum  = |(st & ABN_GRP);
    st_en = st & en[EV_W-1:0];
    n_hit = en[NSUM_POS] & (|(st_en & NRM_GRP));
    a_hit = en[ASUM_POS] & (|(st_en & ABN_GRP));
    irq_d = n_hit | a_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R9: an enabled bit of an open group raises the line one cycle later
  a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ((en[NSUM_POS] && ((st & en[EV_W-1:0] & NRM_GRP) != '0)) ||
     (en[ASUM_POS] && ((st & en[EV_W-1:0] & ABN_GRP) != '0))) |=> irq);

  // R10: no enabled pending bit means the line is low one cycle later
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((st & en[EV_W-1:0]) == '0) |=> !irq);
endmodule

// File: rtl/irqsc_readback.sv
module irqsc_readback
  import irqsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             sel_st,
  input  logic             sel_en,
  input  logic [REG_W-1:0] st_word,
  input  logic [REG_W-1:0] en_word,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] mux_d, rdata_q;

  always_comb begin
    mux_d = '0;
    if (sel_st)      mux_d = st_word;
    else if (sel_en) mux_d = en_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= mux_d;
  end

  assign rdata = rdata_q;

  // R12: read data only moves on a read strobe
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqsc_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]    STAT_ADDR = 4'd0,
  parameter logic [ADDR_W-1:0]    EN_ADDR   = 4'd1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EV_W-1:0]   ev_strobe,
  input  logic [PS_W-1:0]   rx_state,
  input  logic [PS_W-1:0]   tx_state,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [1:0]       rst_pipe;
  logic             rst_ns;
  logic             sel_st, sel_en, wr_st, wr_en;
  logic [EV_W-1:0]  st_bits;
  logic [REG_W-1:0] en_word, st_word;
  logic             nsum, asum;
  logic             unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  always_comb begin
    sel_st = (reg_addr == STAT_ADDR);
    sel_en = (reg_addr == EN_ADDR);
    wr_st  = reg_wr & sel_st;
    wr_en  = reg_wr & sel_en;
  end

  assign unused_wdata = 1'b0;

  irqsc_status_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_ns),
    .ev       (ev_strobe),
    .clr_we   (wr_st),
    .clr_data (reg_wdata[EV_W-1:0]),
    .st_q     (st_bits)
  );

  irqsc_enable_reg u_en (
    .clk   (clk),
    .rst_n (rst_ns),
    .we    (wr_en),
    .wdata (reg_wdata),
    .en_q  (en_word)
  );

  irqsc_irq_gen u_irq (
    .clk   (clk),
    .rst_n (rst_ns),
    .st    (st_bits),
    .en    (en_word),
    .nsum  (nsum),
    .asum  (asum),
    .irq   (irq)
  );

  assign st_word = {{PAD_W{1'b0}}, tx_state, rx_state, nsum, asum, st_bits};

  irqsc_readback u_rd (
    .clk     (clk),
    .rst_n   (rst_ns),
    .rd_en   (reg_rd),
    .sel_st  (sel_st),
    .sel_en  (sel_en),
    .st_word (st_word),
    .en_word (en_word),
    .rdata   (reg_rdata)
  );

  // R5/R6: summaries agree with the group contents
  a_r5_nsum: assert property (@(posedge clk) disable iff (!rst_ns)
    nsum == ((st_bits & NRM_GRP) != '0));
  a_r6_asum: assert property (@(posedge clk) disable iff (!rst_ns)
    asum == ((st_bits & ABN_GRP) != '0));
endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
  localparam logic [14:0] T_NRM  = 15'h4845;
  localparam logic [14:0] T_ABN  = 15'h27AA;
  localparam logic [14:0] T_IMPL = T_NRM | T_ABN;
  localparam logic [31:0] T_ENW  = 32'h0001_EFEF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] ev;
  logic [2:0]  rxs, txs;
  logic [3:0]  addr;
  logic        wr, rd;
  logic [31:0] wdata, rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [14:0] m_st;
  logic [31:0] m_en;

  always #5 clk = ~clk;

  irq_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev), .rx_state(rxs), .tx_state(txs),
    .reg_addr(addr), .reg_wr(wr), .reg_rd(rd), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] st_word();
    return {9'd0, txs, rxs, |(m_st & T_NRM), |(m_st & T_ABN), m_st};
  endfunction

  function automatic logic exp_irq();
    return (m_en[16] && |(m_st & m_en[14:0] & T_NRM)) ||
           (m_en[15] && |(m_st & m_en[14:0] & T_ABN));
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic cyc(logic [14:0] e, logic w, logic [3:0] a, logic [31:0] d);
    ev = e; wr = w; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    ev = '0; wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [31:0] v);
    addr = a; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; v = rdata;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; ev = '0; rxs = '0; txs = '0; addr = '0;
    wr = 1'b0; rd = 1'b0; wdata = '0; m_st = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rdata", rdata, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    rd_reg(4'd0, v); check("R1 status", v, 32'h0);
    rd_reg(4'd1, v); check("R1 enable", v, 32'h0);

    // R2 R3 R5 R6: single-bit set and clear sweep
    for (int b = 0; b < 15; b++) begin
      cyc(15'(1 << b), 1'b0, 4'd0, '0);
      m_st = 15'(1 << b) & T_IMPL;
      rd_reg(4'd0, v); check("R2 R5 R6 set", v, st_word());
      cyc('0, 1'b1, 4'd0, v);
      m_st = '0;
      rd_reg(4'd0, v); check("R3 clear", v, st_word());
    end

    // R3: partial clear with write-back patterns
    for (int p = 0; p < 8; p++) begin
      logic [14:0] setv, clrv;
      setv = 15'h7FFF ^ 15'(p * 15'h0923);
      clrv = 15'(p * 15'h1357);
      cyc(setv, 1'b0, 4'd0, '0);
      m_st = setv & T_IMPL;
      cyc('0, 1'b1, 4'd0, {17'd0, clrv});
      m_st = m_st & ~clrv;
      rd_reg(4'd0, v); check("R3 R5 R6 partial", v, st_word());
      cyc('0, 1'b1, 4'd0, 32'hFFFF_FFFF); m_st = '0;
    end

    // R4: event and clear on the same bit in the same cycle
    cyc(15'h0041, 1'b0, 4'd0, '0);
    cyc(15'h0040, 1'b1, 4'd0, 32'h0000_0041);
    m_st = 15'h0040;
    rd_reg(4'd0, v); check("R4 event wins", v, st_word());
    cyc('0, 1'b1, 4'd0, 32'h7FFF); m_st = '0;

    // R7: summary and upper bits not writable
    cyc(15'h0002, 1'b0, 4'd0, '0); m_st = 15'h0002;
    cyc('0, 1'b1, 4'd0, 32'hFFFF_8000);
    rd_reg(4'd0, v); check("R7 upper write", v, st_word());
    cyc('0, 1'b1, 4'd0, 32'h2); m_st = '0;

    // R8 enable read/write
    cyc('0, 1'b1, 4'd1, 32'hFFFF_FFFF); m_en = T_ENW;
    rd_reg(4'd1, v); check("R8 all ones", v, T_ENW);
    cyc('0, 1'b1, 4'd1, 32'h5A5A_A5A5); m_en = 32'h5A5A_A5A5 & T_ENW;
    rd_reg(4'd1, v); check("R8 pattern", v, m_en);

    // R9 R10 gating matrix
    for (int b = 0; b < 15; b++) begin
      if (T_IMPL[b]) begin
        for (int g = 0; g < 4; g++) begin
          m_en = 32'(1 << b) | (32'(g) << 15);
          cyc('0, 1'b1, 4'd1, m_en);
          cyc(15'(1 << b), 1'b0, 4'd0, '0);
          m_st = 15'(1 << b);
          check("R9 before edge", {31'd0, irq}, 32'h0);
          idle();
          check("R9 irq raise", {31'd0, irq}, {31'd0, exp_irq()});
          cyc('0, 1'b1, 4'd0, 32'(1 << b)); m_st = '0;
          idle();
          check("R10 irq drop", {31'd0, irq}, 32'h0);
        end
      end
    end

    // R9: a set but disabled bit keeps irq low with both gates open
    m_en = 32'h0001_8001; cyc('0, 1'b1, 4'd1, m_en);
    cyc(15'h0004, 1'b0, 4'd0, '0); m_st = 15'h0004;
    idle(); check("R9 bit disabled", {31'd0, irq}, 32'h0);
    cyc('0, 1'b1, 4'd0, 32'h4); m_st = '0;

    // R11 state fields sweep, read-only
    for (int r = 0; r < 8; r++) begin
      for (int t = 0; t < 8; t++) begin
        rxs = 3'(r); txs = 3'(t);
        rd_reg(4'd0, v); check("R11 fields", v, st_word());
      end
    end
    cyc('0, 1'b1, 4'd0, 32'h007E_0000);
    rd_reg(4'd0, v); check("R11 fields read-only", v, st_word());
    rxs = '0; txs = '0;

    // R12 other addresses, and hold without read strobe
    for (int a = 2; a < 16; a++) begin
      cyc('0, 1'b1, 4'(a), 32'hFFFF_FFFF);
      rd_reg(4'(a), v); check("R12 unmapped read", v, 32'h0);
    end
    rd_reg(4'd1, v); check("R12 unmapped write", v, m_en);
    cyc(15'h0800, 1'b0, 4'd0, '0); m_st = 15'h0800;
    idle();
    check("R12 hold", rdata, m_en);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule